// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block arbitrates among sixteen fixed interrupt priority slots and hands the processor the 16-bit word address of the vector entry for the winning slot. Slot 15 is the most urgent and slot 0 the least. The vector table sits in a fixed descending region at the top of the address space, so the entry address of any slot follows directly from its number. Each slot has a class chosen at run time: maskable, non-maskable or reset. Only maskable slots obey the global interrupt enable. Every class still obeys its own per-slot enable.

A slot's pending state comes from one of two sources, fixed per slot by a parameter mask. A level slot takes its pending bit straight from an input. The peripheral drives that input as the OR of several of its own flags and clears those flags itself. A latched slot captures a one-cycle event pulse in an internal flag. The controller clears that flag itself when a maskable request from that slot is acknowledged.

Once a request is raised, the winning slot and vector are registered and frozen until the processor acknowledges. One slot is tied to a watchdog. Its enable only counts while the watchdog runs as an interval timer.

Top module: `ivc_top`

## Requirements
- R1: After reset `irq_o` is 0, `slot_o` is 0 and `vec_o` is 0xFFE0.
- R2: Among all qualified pending slots, the one with the highest index is presented on `slot_o`.
- R3: While `irq_o` is 1, `vec_o` equals 0xFFE0 + 2 × `slot_o` (slot 15 → 0xFFFE, slot 14 → 0xFFFC, slot 0 → 0xFFE0).
- R4: A slot of class maskable (code 2'b00, and also the unused code 2'b11) qualifies only when its pending bit, its `ie_i` bit and `gie_i` are all 1.
- R5: A slot of class non-maskable (2'b01) or reset (2'b10) qualifies when its pending bit and its `ie_i` bit are 1, whatever `gie_i` is. Class codes sit at `cls_i[2*s+1:2*s]`.
- R6: The watchdog slot (index 10 by default) qualifies only while `wdt_interval_i` is 1. With `wdt_interval_i` at 0 its `ie_i` bit has no effect.
- R7: A level slot (mask 0xD032 by default: slots 15, 14, 12, 5, 4, 1) is pending exactly while its `src_i` bit is 1. An acknowledge does not clear it.
- R8: A latched slot sets its flag on a `src_i` pulse. An acknowledge of that slot clears the flag only if the slot's class is maskable. Non-maskable and reset latched flags survive the acknowledge.
- R9: Once `irq_o` is 1, `slot_o` and `vec_o` hold their values until `ack_i`, even if a higher slot becomes pending.
- R10: `ack_i` while `irq_o` is 1 drives `irq_o` to 0 for one cycle. On the next edge arbitration restarts from the updated pending state.
- R11: If a latched slot receives a new pulse in the same cycle its flag is cleared by acknowledge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 16 | Per-slot event pulse (latched slots) or ORed level (level slots) |
| ie_i | input | 16 | Per-slot individual enable |
| gie_i | input | 1 | Global interrupt enable, applies to maskable slots only |
| cls_i | input | 32 | Two-bit class per slot: 00 maskable, 01 non-maskable, 10 reset |
| wdt_interval_i | input | 1 | 1 when the watchdog runs as an interval timer |
| ack_i | input | 1 | Acknowledge of the presented request |
| irq_o | output | 1 | Interrupt request |
| slot_o | output | 4 | Index of the presented slot |
| vec_o | output | 16 | Word address of the presented vector entry |

## Verification
Every slot is raised alone, and its index and vector address are compared with 0xFFE0 plus twice the index. This catches any error in the address arithmetic per slot. Every pair of slots is then raised together with the global enable held off, and the enable is released in one step. This isolates pure priority order from the hold behaviour, since both flags are pending before arbitration. Directed sequences then try the qualifications that tell the classes apart: global enable off against non-maskable and reset classes, the watchdog mode bit, and individual enables. Further sequences try acknowledge against level slots, latched maskable slots and latched non-maskable slots, a higher slot arriving during a hold, and a new event colliding with the clearing acknowledge.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [1:0] {
    CLS_MASKABLE = 2'b00,
    CLS_NONMASK  = 2'b01,
    CLS_RESET    = 2'b10,
    CLS_SPARE    = 2'b11
  } slot_class_e;

  // Maskable covers the spare code as well
  function automatic logic class_is_maskable(logic [1:0] c);
    return (c != CLS_NONMASK) && (c != CLS_RESET);
  endfunction

  // Word address of a vector entry: base plus two bytes per slot
  function automatic logic [31:0] vec_word(logic [31:0] base, logic [31:0] idx);
    return base + (idx << 1);
  endfunction

endpackage

// File: rtl/ivc_flag_bank.sv
module ivc_flag_bank #(
  parameter int          N_SLOTS    = 16,
  parameter logic [63:0] LEVEL_MASK = 64'hD032
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] src_i,
  input  logic [N_SLOTS-1:0] clr_i,
  output logic [N_SLOTS-1:0] pend_o
);

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    if (LEVEL_MASK[s]) begin : g_level
      assign pend_o[s] = src_i[s];
    end else begin : g_latch
      logic flag_q;
      always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= (flag_q & ~clr_i[s]) | src_i[s];
      end
      assign pend_o[s] = flag_q;

      // R8: a clear with no new event empties the flag
      p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i[s] && !src_i[s] |=> !pend_o[s]);
      // R11: a new event always leaves the flag set
      p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        src_i[s] |=> pend_o[s]);
    end
  end

endmodule

// File: rtl/ivc_qualify.sv
module ivc_qualify #(
  parameter int N_SLOTS  = 16,
  parameter int WDT_SLOT = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SLOTS-1:0]   pend_i,
  input  logic [N_SLOTS-1:0]   ie_i,
  input  logic                 gie_i,
  input  logic [2*N_SLOTS-1:0] cls_i,
  input  logic                 wdt_interval_i,
  output logic [N_SLOTS-1:0]   req_o
);
  import ivc_pkg::*;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic ie_eff;
    logic maskable;
    if (s == WDT_SLOT) begin : g_wdt
      assign ie_eff = ie_i[s] & wdt_interval_i;
    end else begin : g_plain
      assign ie_eff = ie_i[s];
    end
    assign maskable = class_is_maskable(cls_i[2*s +: 2]);
    assign req_o[s] = pend_i[s] & ie_eff & (gie_i | ~maskable);

    // R4: no maskable request without the global enable
    p_gie_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_o[s] && maskable |-> gie_i);
    // R5: every class honours its own enable and pending bit
    p_ie_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_o[s] |-> ie_i[s] && pend_i[s]);
  end

  if (WDT_SLOT < N_SLOTS) begin : g_wdt_chk
    // R6: watchdog slot silent outside interval mode
    p_wdt_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wdt_interval_i |-> !req_o[WDT_SLOT]);
  end

endmodule

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick #(
  parameter int N_SLOTS = 16,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   win_o
);

  always_comb begin
    win_o = '0;
    for (int s = 0; s < N_SLOTS; s++) begin
      if (req_i[s]) win_o = IDX_W'(s);
    end
    any_o = |req_i;
  end

  // R2: winner is requesting and nothing above it is
  p_pick_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req_i[win_o] && ((req_i >> win_o) >> 1) == '0);

endmodule

// File: rtl/ivc_top.sv
module ivc_top #(
  parameter int          N_SLOTS    = 16,
  parameter int          ADDR_W     = 16,
  parameter logic [31:0] VEC_BASE   = 32'h0000_FFE0,
  parameter logic [63:0] LEVEL_MASK = 64'hD032,
  parameter int          WDT_SLOT   = 10,
  localparam int         IDX_W      = $clog2(N_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SLOTS-1:0]   src_i,
  input  logic [N_SLOTS-1:0]   ie_i,
  input  logic                 gie_i,
  input  logic [2*N_SLOTS-1:0] cls_i,
  input  logic                 wdt_interval_i,
  input  logic                 ack_i,
  output logic                 irq_o,
  output logic [IDX_W-1:0]     slot_o,
  output logic [ADDR_W-1:0]    vec_o
);
  import ivc_pkg::*;

  logic [N_SLOTS-1:0] pend;
  logic [N_SLOTS-1:0] req;
  logic [N_SLOTS-1:0] clr;
  logic               any;
  logic [IDX_W-1:0]   win;
  logic               irq_q;
  logic [IDX_W-1:0]   slot_q;
  logic [ADDR_W-1:0]  vec_q;
  logic               ack_take;

  assign ack_take = irq_q & ack_i;

  // Auto-clear only for the acknowledged slot when maskable
  for (genvar s = 0; s < N_SLOTS; s++) begin : g_clr
    assign clr[s] = ack_take && (slot_q == IDX_W'(s)) &&
                    class_is_maskable(cls_i[2*s +: 2]);
  end

  ivc_flag_bank #(.N_SLOTS(N_SLOTS), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(clr), .pend_o(pend)
  );

  ivc_qualify #(.N_SLOTS(N_SLOTS), .WDT_SLOT(WDT_SLOT)) u_qual (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .ie_i(ie_i), .gie_i(gie_i),
    .cls_i(cls_i), .wdt_interval_i(wdt_interval_i), .req_o(req)
  );

  ivc_prio_pick #(.N_SLOTS(N_SLOTS)) u_pick (
    .clk(clk), .rst_n(rst_n), .req_i(req), .any_o(any), .win_o(win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      slot_q <= '0;
      vec_q  <= ADDR_W'(VEC_BASE);
    end else if (ack_take) begin
      irq_q  <= 1'b0;
    end else if (!irq_q) begin
      irq_q  <= any;
      slot_q <= win;
      vec_q  <= ADDR_W'(vec_word(VEC_BASE, 32'(win)));
    end
  end

  assign irq_o  = irq_q;
  assign slot_o = slot_q;
  assign vec_o  = vec_q;

  // R3: presented vector matches presented slot
  p_vec_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> vec_q == ADDR_W'(vec_word(VEC_BASE, 32'(slot_q))));
  // R9: frozen until acknowledge
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !ack_i |=> irq_q && $stable(slot_q) && $stable(vec_q));
  // R10: acknowledge drops the request for a cycle
  p_ack_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && ack_i |=> !irq_q);
  // R8: at most one flag cleared per acknowledge
  p_clr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
  // R2: nothing raised without a qualified request
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q && !any |=> !irq_q);

endmodule

// File: tb/ivc_top_test.sv
module ivc_top_test;

  localparam int          N    = 16;
  localparam logic [15:0] LVL  = 16'hD032;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic [N-1:0]  ie_i = '1;
  logic          gie_i = 1'b0;
  logic [2*N-1:0] cls_i = '0;
  logic          wdt_interval_i = 1'b1;
  logic          ack_i = 1'b0;
  logic          irq_o;
  logic [3:0]    slot_o;
  logic [15:0]   vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ivc_top uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .ie_i(ie_i), .gie_i(gie_i),
    .cls_i(cls_i), .wdt_interval_i(wdt_interval_i), .ack_i(ack_i),
    .irq_o(irq_o), .slot_o(slot_o), .vec_o(vec_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(int s);
    return 16'hFFE0 + 16'(s * 2);
  endfunction

  task automatic chk_req(string req, int s);
    chk(irq_o == 1'b1, req, irq_o, 1);
    chk(slot_o == 4'(s), req, slot_o, s);
    chk(vec_o == exp_vec(s), req, vec_o, exp_vec(s));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src_i = '0; ie_i = '1; gie_i = 1'b0; cls_i = '0;
    wdt_interval_i = 1'b1; ack_i = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  // Raise a set of slots with the global enable off, then release it
  task automatic raise_and_pick(logic [N-1:0] m, string req);
    int top;
    do_reset();
    src_i = m;
    tick();
    src_i = m & LVL;
    tick();
    gie_i = 1'b1;
    tick();
    top = 0;
    for (int s = 0; s < N; s++) if (m[s]) top = s;
    chk_req(req, top);
  endtask

  initial begin
    do_reset();
    // R1: reset state
    chk(irq_o == 1'b0, "R1", irq_o, 0);
    chk(slot_o == 4'd0, "R1", slot_o, 0);
    chk(vec_o == 16'hFFE0, "R1", vec_o, 16'hFFE0);

    // R3: each slot alone
    for (int s = 0; s < N; s++) raise_and_pick(16'(1 << s), "R3");

    // R2: every pair
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        raise_and_pick(16'((1 << a) | (1 << b)), "R2");

    // R4: maskable gating
    do_reset();
    src_i[3] = 1'b1; tick(); src_i = '0; tick();
    chk(irq_o == 1'b0, "R4", irq_o, 0);
    ie_i[3] = 1'b0; gie_i = 1'b1; tick(); tick();
    chk(irq_o == 1'b0, "R4", irq_o, 0);
    ie_i[3] = 1'b1; tick();
    chk_req("R4", 3);

    // R5: non-maskable and reset ignore the global enable
    do_reset();
    cls_i[29:28] = 2'b01; ie_i[14] = 1'b0; src_i[14] = 1'b1;
    tick(); tick();
    chk(irq_o == 1'b0, "R5", irq_o, 0);
    ie_i[14] = 1'b1; tick();
    chk_req("R5", 14);
    cls_i[31:30] = 2'b10; src_i[15] = 1'b1; ack_i = 1'b1; tick();
    ack_i = 1'b0;
    chk(irq_o == 1'b0, "R10", irq_o, 0);
    tick();
    chk_req("R5", 15);

    // R6: watchdog slot mode
    do_reset();
    gie_i = 1'b1; wdt_interval_i = 1'b0;
    src_i[10] = 1'b1; tick(); src_i = '0; tick(); tick();
    chk(irq_o == 1'b0, "R6", irq_o, 0);
    wdt_interval_i = 1'b1; tick();
    chk_req("R6", 10);

    // R7: level slot survives acknowledge
    do_reset();
    gie_i = 1'b1; src_i[12] = 1'b1; tick();
    chk_req("R7", 12);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk(irq_o == 1'b0, "R10", irq_o, 0);
    tick();
    chk_req("R7", 12);

    // R8: latched maskable cleared, latched non-maskable kept
    do_reset();
    gie_i = 1'b1; src_i[7] = 1'b1; tick(); src_i = '0; tick();
    chk_req("R8", 7);
    ack_i = 1'b1; tick(); ack_i = 1'b0; tick();
    chk(irq_o == 1'b0, "R8", irq_o, 0);
    cls_i[19:18] = 2'b01; src_i[9] = 1'b1; tick(); src_i = '0; tick();
    chk_req("R8", 9);
    ack_i = 1'b1; tick(); ack_i = 1'b0; tick();
    chk_req("R8", 9);

    // R9: hold against a higher arrival, then R10 re-arbitration
    do_reset();
    gie_i = 1'b1; src_i[3] = 1'b1; tick(); src_i = '0; tick();
    chk_req("R9", 3);
    src_i[8] = 1'b1; tick(); src_i = '0; tick(); tick();
    chk_req("R9", 3);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk(irq_o == 1'b0, "R10", irq_o, 0);
    tick();
    chk_req("R10", 8);

    // R11: new event during the clearing acknowledge
    do_reset();
    gie_i = 1'b1; src_i[7] = 1'b1; tick(); src_i = '0; tick();
    chk_req("R11", 7);
    ack_i = 1'b1; src_i[7] = 1'b1; tick(); ack_i = 1'b0; src_i = '0;
    chk(irq_o == 1'b0, "R11", irq_o, 0);
    tick();
    chk_req("R11", 7);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule